// File: doc/BRIEF.md
# BCD Calendar Clock Core

This block keeps the time of day and the calendar as packed BCD bytes. A one-cycle strobe arriving at 100 Hz advances an internal working record through hundredths of a second, seconds, minutes, hours, weekday, day of month, month and a two-digit year. Carries ripple from the hundredths up to the year in the same cycle. Month lengths are handled, and the February length follows the leap-year rule.

Hosts do not read the working record directly. They read a second record, the user copy, which is refreshed from the working record as a whole one cycle after each step. A host that needs a consistent multi-byte read raises a hold input, which defers the refresh until the hold is released. Host writes land in the user copy at once. On the next strobe, the whole user copy becomes the new working record in place of a step. The hour byte selects 24-hour or 12-hour counting and, in 12-hour counting, carries a PM flag.

Top module: `bcd_calendar_core`

## Requirements
- R1: After reset the eight time registers read hundredths 00, seconds 00, minutes 00, hour 00 (24-hour), weekday 01, date 01, month 01 and year 00.
- R2: Hundredths count 00..99, and seconds and minutes count 00..59, all in packed BCD (low nibble = units, high nibble = tens). Each field wraps to 00 and carries into the next field.
- R3: In 24-hour counting the hour byte (bit 6 = 0) counts 00..23, and 23:59:59.99 steps to 00:00:00.00 with a carry into the date.
- R4: In 12-hour counting (hour bit 6 = 1, bit 5 = PM, bits 4:0 = BCD hour) the hours run 12, 01, …, 11. The step from 11 to 12 toggles bit 5, and only the PM-to-AM step carries into the date.
- R5: The weekday counts 01..07 and wraps from 07 to 01 on each date carry.
- R6: Months 04, 06, 09 and 11 end after date 30, and the other months except 02 end after date 31. The date then returns to 01 and the month advances.
- R7: February ends after 29 when the BCD year is divisible by 4 (00 counts as divisible), and after 28 otherwise.
- R8: December 31 steps to January 01 of the next year, and year 99 wraps to 00.
- R9: A strobe sampled at a clock edge updates the working record at that edge. The user copy, and so the read data, shows the new value from the following edge.
- R10: While hold is high, the user copy is not refreshed. A refresh deferred by the hold takes place at the first edge after hold is low.
- R11: A write changes its user register at the clock edge, discards any deferred refresh, and makes the next strobe load the whole user copy into the working record in place of a step. Later strobes step from the loaded value.
- R12: Register offsets are 0 hundredths, 1 seconds, 2 minutes, 4 hour, 6 weekday, 8 date, 9 month and A year. Every other offset reads 00, and writes to it change nothing and schedule no load.
- R13: Without a strobe the working record holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle 100 Hz advance strobe |
| hold_i | input | 1 | Defers refresh of the user copy while high |
| wr_en_i | input | 1 | Write strobe for the user copy |
| addr_i | input | 4 | Register offset for read and write |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data from the user copy (combinational on addr_i) |

## Verification
The working record changes at the edge that samples the strobe, and the read data follows one edge later. Each strobe check therefore reads once at the falling edge between those two edges, where it expects the old value, and again at the next falling edge, where it expects the new one. Writes are visible at the falling edge after the write edge, and read data depends only on the offset. Each table vector is driven by eight writes, one loading strobe and one stepping strobe, and is compared two edges after the stepping strobe.

// File: rtl/bcd_cal_pkg.sv
package bcd_cal_pkg;

  localparam int unsigned DATA_W = 8;
  localparam int unsigned ADDR_W = 4;

  typedef logic [DATA_W-1:0] byte_t;

  // Full time record; byte 0 (hund) in the low bits.
  typedef struct packed {
    byte_t year;
    byte_t month;
    byte_t date;
    byte_t dow;
    byte_t hour;
    byte_t minute;
    byte_t second;
    byte_t hund;
  } cal_rec_t;

  // Register offsets decoded by the host port.
  localparam logic [ADDR_W-1:0] OFS_HUND  = 4'h0;
  localparam logic [ADDR_W-1:0] OFS_SEC   = 4'h1;
  localparam logic [ADDR_W-1:0] OFS_MIN   = 4'h2;
  localparam logic [ADDR_W-1:0] OFS_HOUR  = 4'h4;
  localparam logic [ADDR_W-1:0] OFS_DOW   = 4'h6;
  localparam logic [ADDR_W-1:0] OFS_DATE  = 4'h8;
  localparam logic [ADDR_W-1:0] OFS_MONTH = 4'h9;
  localparam logic [ADDR_W-1:0] OFS_YEAR  = 4'hA;

  // Hour byte fields.
  localparam int unsigned HR_MODE12_BIT = 6;
  localparam int unsigned HR_PM_BIT     = 5;

  localparam cal_rec_t CAL_RESET = '{
    year: 8'h00, month: 8'h01, date: 8'h01, dow: 8'h01,
    hour: 8'h00, minute: 8'h00, second: 8'h00, hund: 8'h00
  };

  // Add one to a two-digit packed BCD value (no wrap at 99 handled here).
  function automatic byte_t bcd_inc(input byte_t v);
    byte_t r;
    if (v[3:0] == 4'd9) r = {v[7:4] + 4'd1, 4'd0};
    else                r = {v[7:4], v[3:0] + 4'd1};
    return r;
  endfunction

  // 10 = 2 (mod 4), so tens*2 + units decides divisibility by 4.
  function automatic logic year_is_leap(input byte_t y);
    logic [4:0] s;
    s = {y[7:4], 1'b0} + {1'b0, y[3:0]};
    return (s[1:0] == 2'b00);
  endfunction

  function automatic byte_t month_last_date(input byte_t m, input logic leap);
    byte_t r;
    case (m)
      8'h02:                      r = leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: r = 8'h30;
      default:                    r = 8'h31;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/cal_time_step.sv
// Next value of the time-of-day fields for one strobe, plus the date carry.
module cal_time_step
  import bcd_cal_pkg::*;
#(
  parameter byte_t HUND_LAST = 8'h99,
  parameter byte_t SEXA_LAST = 8'h59
) (
  input  byte_t hund_i,
  input  byte_t sec_i,
  input  byte_t min_i,
  input  byte_t hour_i,
  output byte_t hund_o,
  output byte_t sec_o,
  output byte_t min_o,
  output byte_t hour_o,
  output logic  day_carry_o
);

  logic c_hund, c_sec, c_min;
  logic mode12, pm;
  byte_t h12;

  assign c_hund = (hund_i == HUND_LAST);
  assign c_sec  = c_hund && (sec_i == SEXA_LAST);
  assign c_min  = c_sec  && (min_i == SEXA_LAST);
  assign mode12 = hour_i[HR_MODE12_BIT];
  assign pm     = hour_i[HR_PM_BIT];
  assign h12    = {3'b000, hour_i[4:0]};

  always_comb begin
    hund_o = c_hund ? 8'h00 : bcd_inc(hund_i);
    sec_o  = sec_i;
    min_o  = min_i;
    if (c_hund) sec_o = (sec_i == SEXA_LAST) ? 8'h00 : bcd_inc(sec_i);
    if (c_sec)  min_o = (min_i == SEXA_LAST) ? 8'h00 : bcd_inc(min_i);
  end

  always_comb begin
    hour_o      = hour_i;
    day_carry_o = 1'b0;
    if (c_min) begin
      if (mode12) begin
        if (h12 == 8'h11) begin
          hour_o      = {2'b01, ~pm, 5'h12};
          day_carry_o = pm;
        end else if (h12 == 8'h12) begin
          hour_o = {2'b01, pm, 5'h01};
        end else begin
          hour_o = {2'b01, pm, bcd_inc(h12)[4:0]};
        end
      end else begin
        if (hour_i == 8'h23) begin
          hour_o      = 8'h00;
          day_carry_o = 1'b1;
        end else begin
          hour_o = bcd_inc(hour_i);
        end
      end
    end
  end

endmodule

// File: rtl/cal_date_step.sv
// Next value of the calendar fields given the carry out of the hours.
module cal_date_step
  import bcd_cal_pkg::*;
#(
  parameter byte_t DOW_LAST   = 8'h07,
  parameter byte_t MONTH_LAST = 8'h12,
  parameter byte_t YEAR_LAST  = 8'h99
) (
  input  logic  carry_i,
  input  byte_t dow_i,
  input  byte_t date_i,
  input  byte_t month_i,
  input  byte_t year_i,
  output byte_t dow_o,
  output byte_t date_o,
  output byte_t month_o,
  output byte_t year_o
);

  logic  leap;
  byte_t last_date;

  assign leap      = year_is_leap(year_i);
  assign last_date = month_last_date(month_i, leap);

  always_comb begin
    dow_o   = dow_i;
    date_o  = date_i;
    month_o = month_i;
    year_o  = year_i;
    if (carry_i) begin
      dow_o = (dow_i == DOW_LAST) ? 8'h01 : bcd_inc(dow_i);
      if (date_i == last_date) begin
        date_o = 8'h01;
        if (month_i == MONTH_LAST) begin
          month_o = 8'h01;
          year_o  = (year_i == YEAR_LAST) ? 8'h00 : bcd_inc(year_i);
        end else begin
          month_o = bcd_inc(month_i);
        end
      end else begin
        date_o = bcd_inc(date_i);
      end
    end
  end

endmodule

// File: rtl/cal_user_bank.sv
// Host-visible copy: byte writes, offset-decoded reads, deferrable refresh.
module cal_user_bank
  import bcd_cal_pkg::*;
#(
  parameter int unsigned AW = ADDR_W,
  parameter int unsigned DW = DATA_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           refresh_req_i,
  input  cal_rec_t       src_i,
  input  logic           hold_i,
  input  logic           wr_en_i,
  input  logic [AW-1:0]  addr_i,
  input  logic [DW-1:0]  wdata_i,
  output cal_rec_t       user_o,
  output logic           wr_hit_o,
  output logic [DW-1:0]  rdata_o
);

  cal_rec_t user_q, user_d;
  logic     pend_q, pend_d;
  logic     addr_ok, want_refresh, do_refresh;

  always_comb begin
    case (addr_i)
      OFS_HUND, OFS_SEC, OFS_MIN, OFS_HOUR,
      OFS_DOW, OFS_DATE, OFS_MONTH, OFS_YEAR: addr_ok = 1'b1;
      default:                                addr_ok = 1'b0;
    endcase
  end

  assign wr_hit_o     = wr_en_i && addr_ok;
  assign want_refresh = refresh_req_i || pend_q;
  assign do_refresh   = want_refresh && !hold_i;

  always_comb begin
    pend_d = want_refresh && hold_i && !wr_hit_o;
    user_d = user_q;
    if (do_refresh) user_d = src_i;
    if (wr_en_i) begin
      case (addr_i)
        OFS_HUND:  user_d.hund   = wdata_i;
        OFS_SEC:   user_d.second = wdata_i;
        OFS_MIN:   user_d.minute = wdata_i;
        OFS_HOUR:  user_d.hour   = wdata_i;
        OFS_DOW:   user_d.dow    = wdata_i;
        OFS_DATE:  user_d.date   = wdata_i;
        OFS_MONTH: user_d.month  = wdata_i;
        OFS_YEAR:  user_d.year   = wdata_i;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (addr_i)
      OFS_HUND:  rdata_o = user_q.hund;
      OFS_SEC:   rdata_o = user_q.second;
      OFS_MIN:   rdata_o = user_q.minute;
      OFS_HOUR:  rdata_o = user_q.hour;
      OFS_DOW:   rdata_o = user_q.dow;
      OFS_DATE:  rdata_o = user_q.date;
      OFS_MONTH: rdata_o = user_q.month;
      OFS_YEAR:  rdata_o = user_q.year;
      default:   rdata_o = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      user_q <= CAL_RESET;
      pend_q <= 1'b0;
    end else begin
      pend_q <= pend_d;
      if (do_refresh || wr_en_i) user_q <= user_d;
    end
  end

  assign user_o = user_q;

endmodule

// File: rtl/bcd_calendar_core.sv
module bcd_calendar_core
  import bcd_cal_pkg::*;
#(
  parameter int unsigned AW = ADDR_W,
  parameter int unsigned DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_i,
  input  logic          hold_i,
  input  logic          wr_en_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o
);

  cal_rec_t int_q, int_d, stepped, user_q;
  logic     load_pend_q, load_pend_d;
  logic     upd_q;
  logic     day_carry, wr_hit;

  cal_time_step u_time (
    .hund_i      (int_q.hund),
    .sec_i       (int_q.second),
    .min_i       (int_q.minute),
    .hour_i      (int_q.hour),
    .hund_o      (stepped.hund),
    .sec_o       (stepped.second),
    .min_o       (stepped.minute),
    .hour_o      (stepped.hour),
    .day_carry_o (day_carry)
  );

  cal_date_step u_date (
    .carry_i (day_carry),
    .dow_i   (int_q.dow),
    .date_i  (int_q.date),
    .month_i (int_q.month),
    .year_i  (int_q.year),
    .dow_o   (stepped.dow),
    .date_o  (stepped.date),
    .month_o (stepped.month),
    .year_o  (stepped.year)
  );

  cal_user_bank #(.AW(AW), .DW(DW)) u_bank (
    .clk           (clk),
    .rst_n         (rst_n),
    .refresh_req_i (upd_q),
    .src_i         (int_q),
    .hold_i        (hold_i),
    .wr_en_i       (wr_en_i),
    .addr_i        (addr_i),
    .wdata_i       (wdata_i),
    .user_o        (user_q),
    .wr_hit_o      (wr_hit),
    .rdata_o       (rdata_o)
  );

  // Next state: a pending host load replaces the step on the strobe.
  always_comb begin
    int_d       = load_pend_q ? user_q : stepped;
    load_pend_d = load_pend_q;
    if (tick_i) load_pend_d = 1'b0;
    if (wr_hit) load_pend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      int_q       <= CAL_RESET;
      load_pend_q <= 1'b0;
      upd_q       <= 1'b0;
    end else begin
      load_pend_q <= load_pend_d;
      upd_q       <= tick_i;
      if (tick_i) int_q <= int_d;
    end
  end

endmodule

// File: rtl/bcd_calendar_core_chk.sv
module bcd_calendar_core_chk
  import bcd_cal_pkg::*;
(
  input logic     clk,
  input logic     rst_n,
  input logic     tick_i,
  input logic     hold_i,
  input logic     wr_en_i,
  input cal_rec_t int_q,
  input cal_rec_t user_q
);

  p_sexa_bcd_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (int_q.hund[3:0] <= 4'd9) && (int_q.second <= 8'h59) && (int_q.second[3:0] <= 4'd9)
    && (int_q.minute <= 8'h59) && (int_q.minute[3:0] <= 4'd9));

  p_hour24_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !int_q.hour[HR_MODE12_BIT] |-> (int_q.hour <= 8'h23));

  p_hour12_r4: assert property (@(posedge clk) disable iff (!rst_n)
    int_q.hour[HR_MODE12_BIT] |-> (int_q.hour[4:0] >= 5'h01 && int_q.hour[4:0] <= 5'h12));

  p_dow_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (int_q.dow >= 8'h01) && (int_q.dow <= 8'h07));

  p_date_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (int_q.date >= 8'h01) && (int_q.date <= 8'h31) && (int_q.month >= 8'h01) && (int_q.month <= 8'h12));

  p_feb_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (int_q.month == 8'h02) |-> (int_q.date <= 8'h29));

  p_hold_freeze_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_i && !wr_en_i) |=> $stable(user_q));

  p_idle_stable_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |=> $stable(int_q));

endmodule

bind bcd_calendar_core bcd_calendar_core_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .tick_i  (tick_i),
  .hold_i  (hold_i),
  .wr_en_i (wr_en_i),
  .int_q   (int_q),
  .user_q  (user_q)
);

// File: tb/bcd_calendar_core_bench.sv
module bcd_calendar_core_bench;
  import bcd_cal_pkg::*;

  logic       clk;
  logic       rst_n;
  logic       tick, hold, wr_en;
  logic [3:0] addr;
  logic [7:0] wdata, rdata;
  int         n_chk, n_fail;
  logic       done;

  bcd_calendar_core u_bcd_calendar_core (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .hold_i(hold), .wr_en_i(wr_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // Byte i of a record sits at this offset (R12 map).
  localparam logic [3:0] OFS [8] = '{4'h0, 4'h1, 4'h2, 4'h4, 4'h6, 4'h8, 4'h9, 4'hA};

  localparam int NV = 21;
  // {year, month, date, dow, hour, min, sec, hund}
  localparam logic [63:0] VIN [NV] = '{
    64'h23_12_31_07_23_59_59_99, 64'h23_02_28_03_23_59_59_99,
    64'h24_02_28_03_23_59_59_99, 64'h24_02_29_04_23_59_59_99,
    64'h00_02_28_01_23_59_59_99, 64'h96_02_28_01_23_59_59_99,
    64'h05_04_30_06_23_59_59_99, 64'h05_06_30_02_23_59_59_99,
    64'h05_09_30_03_23_59_59_99, 64'h05_11_30_04_23_59_59_99,
    64'h05_01_31_01_23_59_59_99, 64'h05_01_30_07_23_59_59_99,
    64'h99_12_31_05_23_59_59_99, 64'h10_03_15_02_51_59_59_99,
    64'h10_03_15_02_71_59_59_99, 64'h10_03_15_02_72_59_59_99,
    64'h10_03_15_02_52_59_59_99, 64'h10_03_15_02_09_59_59_99,
    64'h10_03_15_02_12_34_56_09, 64'h10_03_15_02_12_34_59_99,
    64'h10_03_15_02_49_59_59_99
  };
  localparam logic [63:0] VEXP [NV] = '{
    64'h24_01_01_01_00_00_00_00, 64'h23_03_01_04_00_00_00_00,
    64'h24_02_29_04_00_00_00_00, 64'h24_03_01_05_00_00_00_00,
    64'h00_02_29_02_00_00_00_00, 64'h96_02_29_02_00_00_00_00,
    64'h05_05_01_07_00_00_00_00, 64'h05_07_01_03_00_00_00_00,
    64'h05_10_01_04_00_00_00_00, 64'h05_12_01_05_00_00_00_00,
    64'h05_02_01_02_00_00_00_00, 64'h05_01_31_01_00_00_00_00,
    64'h00_01_01_06_00_00_00_00, 64'h10_03_15_02_72_00_00_00,
    64'h10_03_16_03_52_00_00_00, 64'h10_03_15_02_61_00_00_00,
    64'h10_03_15_02_41_00_00_00, 64'h10_03_15_02_10_00_00_00,
    64'h10_03_15_02_12_34_56_10, 64'h10_03_15_02_12_35_00_00,
    64'h10_03_15_02_50_00_00_00
  };

  function automatic string vtag(input int i);
    case (i)
      0:             return "R3/R5/R8";
      1, 2, 3, 4, 5: return "R7";
      6, 7, 8, 9:    return "R6";
      10, 11:        return "R6";
      12:            return "R8";
      13, 14, 15, 16, 20: return "R4";
      default:       return "R2";
    endcase
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // Ends one falling edge after the edge that sampled the strobe.
  task automatic pulse_tick();
    @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic rd_check(input string tag, input logic [3:0] a, input logic [7:0] exp);
    logic [7:0] d;
    rd(a, d);
    check(tag, d, exp);
  endtask

  initial begin
    done = 1'b0;
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog (all requirements): actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    n_chk = 0; n_fail = 0;
    rst_n = 1'b0; tick = 1'b0; hold = 1'b0; wr_en = 1'b0; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // Table walk: load via writes and one strobe, step with a second strobe.
    for (int v = 0; v < NV; v++) begin
      if (v == 0) begin
        // R1: reset contents before any table load
        for (int i = 0; i < 8; i++) rd_check("R1 reset", OFS[i], CAL_RESET[8*i +: 8]);
      end
      for (int i = 0; i < 8; i++) wr(OFS[i], VIN[v][8*i +: 8]);
      pulse_tick();
      @(negedge clk);
      pulse_tick();
      @(negedge clk);
      for (int i = 0; i < 8; i++) rd_check(vtag(v), OFS[i], VEXP[v][8*i +: 8]);
    end

    // Directed: restart from reset.
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd_check("R1 hour after reset", 4'h4, 8'h00);

    // R12: unused offsets read zero; write there neither sticks nor schedules a load.
    rd_check("R12 unused 3", 4'h3, 8'h00);
    rd_check("R12 unused 7", 4'h7, 8'h00);
    rd_check("R12 unused F", 4'hF, 8'h00);
    wr(4'h5, 8'h55);
    rd_check("R12 write ignored", 4'h5, 8'h00);
    rd_check("R12 neighbour intact", 4'h6, 8'h01);

    // R9: between the strobe edge and the next edge the old value is still read.
    pulse_tick();
    rd_check("R9 before refresh", 4'h0, 8'h00);
    @(negedge clk);
    rd_check("R9 after refresh / R12 no load", 4'h0, 8'h01);

    // R13: no strobe, no change.
    repeat (10) @(negedge clk);
    rd_check("R13 idle", 4'h0, 8'h01);

    // R10: hold defers the refresh until release.
    hold = 1'b1;
    pulse_tick();
    @(negedge clk);
    @(negedge clk);
    rd_check("R10 frozen", 4'h0, 8'h01);
    hold = 1'b0;
    @(negedge clk);
    rd_check("R10 released", 4'h0, 8'h02);

    // R11: write visible at once; next strobe loads instead of stepping.
    wr(4'h2, 8'h42);
    rd_check("R11 written", 4'h2, 8'h42);
    pulse_tick();
    @(negedge clk);
    rd_check("R11 loaded min", 4'h2, 8'h42);
    rd_check("R11 no step on load", 4'h0, 8'h02);
    pulse_tick();
    @(negedge clk);
    rd_check("R11 steps after load", 4'h0, 8'h03);
    rd_check("R11 min kept", 4'h2, 8'h42);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule